// File: doc/BRIEF.md
# Prioritised Interrupt Level Controller

This block gathers fifteen interrupt sources, numbered 1 to 15, and presents one request level to the processor. Peripherals such as two serial channels and two timers raise single-cycle event pulses. Each pulse latches a pending bit. A mask register gates the pending bits. The highest-numbered source that is enabled appears on the level output, and level 0 means no request. No edge or level shaping is applied to the sources: every input is taken as an internal event pulse. By convention the serial channels use levels 4 and 5 for character events, and a receive overflow uses a separate error level.

Software reaches four registers through a simple register-bus slave port. These are a read-only pending register, a read-write mask register, a write-only clear register and a read-write force register. A force bit raises its level whether or not any hardware source is wired to it. When the processor accepts a level through the acknowledge inputs, the pending bit for that level clears itself. A force bit stays set until software writes it to 0.

The register port and the acknowledge inputs are plain control pins. No data stream passes through the block, so neither interface has back-pressure. A bus write takes effect at the clock edge on which it is presented. A read returns data in the same cycle it is presented.

Top module: `irqh_top`

## Requirements
- R1: After reset, the pending, mask and force registers read 0 and `irq_lvl` is 0.
- R2: A 1 on `src_evt[n]` in a cycle sets pending bit n at the next clock edge. Bit n of every register belongs to level n. The data ports carry bits 15..1 and have no bit 0.
- R3: A write to the clear register at offset 0x50 clears every pending bit written as 1. Pending bits written as 0 are left unchanged.
- R4: If a source pulse and a clear (by register write or by acknowledge) hit the same pending bit in the same cycle, the bit ends up set.
- R5: The mask register at offset 0x4C reads back the value last written. `irq_lvl` is the highest n for which mask bit n is 1 and pending bit n or force bit n is 1.
- R6: The force register at offset 0x54 reads back the value last written. A force bit makes its level request exactly as a pending bit would, and it is still subject to the mask.
- R7: With `ack_valid` high and `ack_lvl` = n (n from 1 to 15), pending bit n is clear after the edge. Force bits are not changed by an acknowledge.
- R8: An acknowledge with `ack_lvl` = 0 changes no register.
- R9: A write to any offset other than 0x4C, 0x50 or 0x54 changes no register, and a read of such an offset returns 0. The pending register at offset 0x48 cannot be written.
- R10: A read of the clear register returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_evt | input | 15 | Event pulses for levels 15..1 |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 15 | Write data, bits 15..1 |
| bus_rdata | output | 15 | Read data, bits 15..1, valid in the cycle of the access |
| ack_valid | input | 1 | Processor accepts a level this cycle |
| ack_lvl | input | 4 | Level being accepted |
| irq_lvl | output | 4 | Highest enabled request, 0 if none |

## Verification
The assertions assume that `src_evt` and `ack_lvl` are free of X whenever reset is released, and that the acknowledge rule is judged only for bits with no simultaneous source pulse, since R4 lets the source win. The bench changes every input only on the falling clock edge, so each stimulus lasts exactly one rising edge. It pulses sources for one cycle at a time, and it only acknowledges levels that software can choose. That keeps the stimulus inside what the checker takes for granted.

// File: rtl/irqh_pkg.sv
package irqh_pkg;
  localparam int unsigned REG_ADDR_W = 8;
  localparam logic [REG_ADDR_W-1:0] OFS_PEND  = 8'h48;
  localparam logic [REG_ADDR_W-1:0] OFS_MASK  = 8'h4C;
  localparam logic [REG_ADDR_W-1:0] OFS_CLEAR = 8'h50;
  localparam logic [REG_ADDR_W-1:0] OFS_FORCE = 8'h54;

  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_PEND,
    SEL_MASK,
    SEL_FORCE
  } rd_sel_e;
endpackage

// File: rtl/irqh_regs.sv
module irqh_regs
  import irqh_pkg::*;
#(
  parameter int unsigned NUM_LVL = 15
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_sel,
  input  logic                  bus_we,
  input  logic [REG_ADDR_W-1:0] bus_addr,
  input  logic [NUM_LVL:1]      bus_wdata,
  input  logic [NUM_LVL:1]      pend_vec,
  output logic [NUM_LVL:1]      bus_rdata,
  output logic [NUM_LVL:1]      mask_q,
  output logic [NUM_LVL:1]      force_q,
  output logic [NUM_LVL:1]      clr_vec
);
  logic    wr_mask, wr_force, wr_clear;
  rd_sel_e rsel;

  assign wr_mask  = bus_sel && bus_we && (bus_addr == OFS_MASK);
  assign wr_force = bus_sel && bus_we && (bus_addr == OFS_FORCE);
  assign wr_clear = bus_sel && bus_we && (bus_addr == OFS_CLEAR);
  assign clr_vec  = wr_clear ? bus_wdata : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q  <= '0;
      force_q <= '0;
    end else begin
      if (wr_mask)  mask_q  <= bus_wdata;
      if (wr_force) force_q <= bus_wdata;
    end
  end

  always_comb begin
    rsel = SEL_NONE;
    if (bus_sel && !bus_we) begin
      unique case (bus_addr)
        OFS_PEND:  rsel = SEL_PEND;
        OFS_MASK:  rsel = SEL_MASK;
        OFS_FORCE: rsel = SEL_FORCE;
        default:   rsel = SEL_NONE;
      endcase
    end
  end

  always_comb begin
    unique case (rsel)
      SEL_PEND:  bus_rdata = pend_vec;
      SEL_MASK:  bus_rdata = mask_q;
      SEL_FORCE: bus_rdata = force_q;
      default:   bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/irqh_pend.sv
module irqh_pend #(
  parameter int unsigned NUM_LVL = 15,
  localparam int unsigned LVL_W = $clog2(NUM_LVL + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_LVL:1]  src_evt,
  input  logic [NUM_LVL:1]  clr_vec,
  input  logic              ack_valid,
  input  logic [LVL_W-1:0]  ack_lvl,
  output logic [NUM_LVL:1]  pend_q
);
  for (genvar g = 1; g <= NUM_LVL; g++) begin : g_bit
    logic ack_hit;
    assign ack_hit = ack_valid && (ack_lvl == LVL_W'(g));
    always_ff @(posedge clk) begin
      if (!rst_n)          pend_q[g] <= 1'b0;
      else if (src_evt[g]) pend_q[g] <= 1'b1;
      else if (clr_vec[g] || ack_hit) pend_q[g] <= 1'b0;
    end
  end
endmodule

// File: rtl/irqh_prio.sv
module irqh_prio #(
  parameter int unsigned NUM_LVL = 15,
  localparam int unsigned LVL_W = $clog2(NUM_LVL + 1)
) (
  input  logic [NUM_LVL:1] req,
  output logic [LVL_W-1:0] lvl
);
  always_comb begin
    lvl = '0;
    for (int i = 1; i <= NUM_LVL; i++) begin
      if (req[i]) lvl = LVL_W'(i);
    end
  end
endmodule

// File: rtl/irqh_top.sv
module irqh_top
  import irqh_pkg::*;
#(
  parameter int unsigned NUM_LVL = 15,
  localparam int unsigned LVL_W = $clog2(NUM_LVL + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_LVL:1]      src_evt,
  input  logic                  bus_sel,
  input  logic                  bus_we,
  input  logic [REG_ADDR_W-1:0] bus_addr,
  input  logic [NUM_LVL:1]      bus_wdata,
  output logic [NUM_LVL:1]      bus_rdata,
  input  logic                  ack_valid,
  input  logic [LVL_W-1:0]      ack_lvl,
  output logic [LVL_W-1:0]      irq_lvl
);
  logic [NUM_LVL:1] pend_q, mask_q, force_q, clr_vec, req_vec;

  irqh_regs #(.NUM_LVL(NUM_LVL)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .pend_vec(pend_q),
    .bus_rdata(bus_rdata), .mask_q(mask_q), .force_q(force_q),
    .clr_vec(clr_vec)
  );

  irqh_pend #(.NUM_LVL(NUM_LVL)) u_pend (
    .clk(clk), .rst_n(rst_n), .src_evt(src_evt), .clr_vec(clr_vec),
    .ack_valid(ack_valid), .ack_lvl(ack_lvl), .pend_q(pend_q)
  );

  assign req_vec = (pend_q | force_q) & mask_q;

  irqh_prio #(.NUM_LVL(NUM_LVL)) u_prio (
    .req(req_vec), .lvl(irq_lvl)
  );
endmodule

// File: rtl/irqh_chk.sv
module irqh_chk
  import irqh_pkg::*;
#(
  parameter int unsigned NUM_LVL = 15,
  localparam int unsigned LVL_W = $clog2(NUM_LVL + 1)
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [NUM_LVL:1]      src_evt,
  input logic                  bus_sel,
  input logic                  bus_we,
  input logic [REG_ADDR_W-1:0] bus_addr,
  input logic [NUM_LVL:1]      bus_wdata,
  input logic                  ack_valid,
  input logic [LVL_W-1:0]      ack_lvl,
  input logic [LVL_W-1:0]      irq_lvl,
  input logic [NUM_LVL:1]      pend_q,
  input logic [NUM_LVL:1]      mask_q,
  input logic [NUM_LVL:1]      force_q
);
  logic [NUM_LVL:1] ack_oh, lvl_oh;
  logic wr_any, wr_clr, wr_frc, wr_msk;

  always_comb begin
    ack_oh = '0;
    lvl_oh = '0;
    for (int i = 1; i <= NUM_LVL; i++) begin
      if (ack_valid && ack_lvl == LVL_W'(i)) ack_oh[i] = 1'b1;
      if (irq_lvl == LVL_W'(i)) lvl_oh[i] = 1'b1;
    end
  end

  assign wr_any = bus_sel && bus_we;
  assign wr_clr = wr_any && bus_addr == OFS_CLEAR;
  assign wr_frc = wr_any && bus_addr == OFS_FORCE;
  assign wr_msk = wr_any && bus_addr == OFS_MASK;

  assert_reset_clean_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (pend_q == '0 && mask_q == '0 && force_q == '0 && irq_lvl == '0));

  assert_src_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (src_evt != '0) |=> ((pend_q & $past(src_evt)) == $past(src_evt)));

  assert_clear_bits_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_clr |=> ((pend_q & $past(bus_wdata) & ~$past(src_evt)) == '0));

  assert_level_enabled_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_lvl != '0) |-> ((lvl_oh & mask_q & (pend_q | force_q)) != '0));

  assert_idle_level_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_lvl == '0) |-> (((pend_q | force_q) & mask_q) == '0));

  assert_ack_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_valid && (ack_oh & src_evt) == '0) |=> ((pend_q & $past(ack_oh)) == '0));

  assert_force_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_valid && !wr_frc) |=> $stable(force_q));

  assert_mask_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_msk |=> $stable(mask_q));
endmodule

bind irqh_top irqh_chk #(.NUM_LVL(NUM_LVL)) u_chk (
  .clk(clk), .rst_n(rst_n), .src_evt(src_evt), .bus_sel(bus_sel),
  .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .ack_valid(ack_valid), .ack_lvl(ack_lvl), .irq_lvl(irq_lvl),
  .pend_q(pend_q), .mask_q(mask_q), .force_q(force_q)
);

// File: tb/sim_irqh_top.sv
module sim_irqh_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:1] src_evt = '0;
  logic        bus_sel = 1'b0, bus_we = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [15:1] bus_wdata = '0;
  logic [15:1] bus_rdata;
  logic        ack_valid = 1'b0;
  logic [3:0]  ack_lvl = '0;
  logic [3:0]  irq_lvl;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  localparam logic [7:0] A_PEND = 8'h48, A_MASK = 8'h4C, A_CLR = 8'h50, A_FRC = 8'h54;

  always #4 clk = ~clk;

  irqh_top u0 (.*);

  function automatic logic [15:1] bit_of(input int n);
    logic [15:0] v = 16'(1) << n;
    return v[15:1];
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:1] d);
    @(negedge clk); bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_sel = 0; bus_we = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [15:1] d);
    @(negedge clk); bus_sel = 1; bus_we = 0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk); bus_sel = 0;
  endtask

  task automatic pulse(input logic [15:1] s);
    @(negedge clk); src_evt = s;
    @(negedge clk); src_evt = '0;
  endtask

  task automatic ack(input logic [3:0] l);
    @(negedge clk); ack_valid = 1; ack_lvl = l;
    @(negedge clk); ack_valid = 0; ack_lvl = '0;
  endtask

  task automatic t_reset();
    logic [15:1] d;
    rd(A_PEND, d); chk("R1 pend", int'(d), 0);
    rd(A_MASK, d); chk("R1 mask", int'(d), 0);
    rd(A_FRC, d);  chk("R1 force", int'(d), 0);
    chk("R1 level", int'(irq_lvl), 0);
  endtask

  task automatic t_source();
    logic [15:1] d;
    pulse(bit_of(4) | bit_of(5));
    rd(A_PEND, d); chk("R2 pend set", int'(d), int'(bit_of(4) | bit_of(5)));
    chk("R5 masked level", int'(irq_lvl), 0);
  endtask

  task automatic t_mask();
    logic [15:1] d;
    wr(A_MASK, 15'h7FFF);
    chk("R5 level top", int'(irq_lvl), 5);
    wr(A_MASK, bit_of(4));
    rd(A_MASK, d); chk("R5 mask readback", int'(d), int'(bit_of(4)));
    chk("R5 level gated", int'(irq_lvl), 4);
    wr(A_MASK, 15'h7FFF);
  endtask

  task automatic t_clear();
    logic [15:1] d;
    wr(A_CLR, bit_of(5));
    rd(A_PEND, d); chk("R3 clear one", int'(d), int'(bit_of(4)));
    wr(A_CLR, '0);
    rd(A_PEND, d); chk("R3 zero keeps", int'(d), int'(bit_of(4)));
    rd(A_CLR, d); chk("R10 clear reads 0", int'(d), 0);
  endtask

  task automatic t_set_wins();
    logic [15:1] d;
    @(negedge clk); src_evt = bit_of(6); bus_sel = 1; bus_we = 1;
    bus_addr = A_CLR; bus_wdata = bit_of(6);
    @(negedge clk); src_evt = '0; bus_sel = 0; bus_we = 0;
    rd(A_PEND, d); chk("R4 set beats clear", int'(d), int'(bit_of(4) | bit_of(6)));
    @(negedge clk); src_evt = bit_of(6); ack_valid = 1; ack_lvl = 4'd6;
    @(negedge clk); src_evt = '0; ack_valid = 0; ack_lvl = '0;
    rd(A_PEND, d); chk("R4 set beats ack", int'(d), int'(bit_of(4) | bit_of(6)));
  endtask

  task automatic t_ack();
    logic [15:1] d;
    chk("R5 level 6", int'(irq_lvl), 6);
    ack(4'd6);
    rd(A_PEND, d); chk("R7 ack clears", int'(d), int'(bit_of(4)));
    chk("R7 next level", int'(irq_lvl), 4);
    ack(4'd0);
    rd(A_PEND, d); chk("R8 ack zero", int'(d), int'(bit_of(4)));
  endtask

  task automatic t_force();
    logic [15:1] d;
    wr(A_FRC, bit_of(15));
    rd(A_FRC, d); chk("R6 force readback", int'(d), int'(bit_of(15)));
    chk("R6 force level", int'(irq_lvl), 15);
    ack(4'd15);
    rd(A_FRC, d); chk("R7 force kept", int'(d), int'(bit_of(15)));
    chk("R7 forced level stays", int'(irq_lvl), 15);
    wr(A_MASK, 15'h7FFF & ~bit_of(15));
    chk("R6 force masked", int'(irq_lvl), 4);
    wr(A_FRC, '0);
    wr(A_MASK, 15'h7FFF);
  endtask

  task automatic t_unmapped();
    logic [15:1] d;
    wr(8'h60, 15'h7FFF);
    rd(8'h60, d); chk("R9 unmapped reads 0", int'(d), 0);
    wr(A_PEND, 15'h7FFF);
    rd(A_PEND, d); chk("R9 pend not writable", int'(d), int'(bit_of(4)));
    rd(A_MASK, d); chk("R9 mask untouched", int'(d), 16'h7FFF);
    rd(A_FRC, d);  chk("R9 force untouched", int'(d), 0);
    chk("R9 level", int'(irq_lvl), 4);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_source();
    t_mask();
    t_clear();
    t_set_wins();
    t_ack();
    t_force();
    t_unmapped();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule